// File: doc/BRIEF.md
# UART Receive Idle-Timeout Detector

This block sits beside a UART receiver and watches for a quiet line after data has arrived. When a data character is received, it loads a down-counter with a programmed maximum idle count. It then counts whole idle character periods on the bit-rate tick. The length of one idle character comes from the current frame settings: one start bit, the data bits, one optional parity bit and one or two stop bits. When the counter reaches zero, the block emits a one-cycle buffer-close pulse and raises a held interrupt request. The receive path uses these to hand a partly filled buffer to software, so the timeout marks the end of a frame.

Any non-idle bit time, such as a start bit or noise, restarts the bit count within the idle character in progress. A maximum idle count of zero turns the feature off. After a timeout the detector stays disarmed until the next data character, so one gap produces one timeout.

The controller has two states. In `ST_DISARMED` it ignores ticks. In `ST_COUNTING` it decrements once per completed idle character. Its transitions are:
- **arm**: a character strobe while the maximum idle count is non-zero, from either state, to `ST_COUNTING`.
- **reload**: a character strobe while already in `ST_COUNTING`; the state stays the same and the counter is reloaded.
- **expire**: the last idle character completes, from `ST_COUNTING` to `ST_DISARMED`, with a pulse.
- **disable**: the maximum idle count is zero, from `ST_COUNTING` to `ST_DISARMED`, without a pulse.

Top module: `uart_idle_timeout`

## Requirements
- R1: No idle counting and no timeout happen until a data character has been received. After reset or after a timeout, `idle_count` reads 0 and `buf_close` stays low, whatever the ticks do.
- R2: When the down-counter reaches zero, `buf_close` is high for exactly one cycle. That cycle is the one after the clock edge that samples the tick completing the last idle character. At that point `idle_count` reads 0.
- R3: When `max_idle` is 0, a character strobe does not arm the detector. No timeout is produced and `idle_count` stays 0.
- R4: An idle character lasts `1 + D + P + S` ticks:
  - D is `data_bits`, the data bit count written as a plain binary number. It is clamped to the range 5..9.
  - P is 1 when `parity_en` is 1.
  - S is 2 when `two_stop` is 1, and 1 otherwise.
- R5: A tick with `line_idle` low restarts the bit count of the idle character in progress. The next full character length of idle ticks is then needed before the counter decrements.
- R6: A character strobe with `max_idle` non-zero loads `idle_count` with `max_idle` on the next edge. It also restarts the bit count. After that, `idle_count` decreases by one per completed idle character and never rises without a strobe.
- R7: After a timeout, no further `buf_close` occurs until another character strobe arrives.
- R8: `irq` rises together with `buf_close` and stays high until `irq_clear` is seen. If a timeout and `irq_clear` fall on the same edge, the timeout wins.
- R9: While reset is applied, `buf_close`, `irq` and `idle_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| line_idle | input | 1 | Sampled line is at the mark (idle) level |
| rx_char_strobe | input | 1 | A data character has been received |
| data_bits | input | 4 | Data bit count, 5..9, clamped |
| parity_en | input | 1 | Frame carries a parity bit |
| two_stop | input | 1 | Frame uses two stop bits |
| max_idle | input | 16 | Idle characters before timeout; 0 disables |
| irq_clear | input | 1 | Clears the held interrupt request |
| buf_close | output | 1 | One-cycle buffer-close pulse on timeout |
| irq | output | 1 | Held maskable interrupt request |
| idle_count | output | 16 | Current value of the idle down-counter |

## Verification
The hardest case to reach is a partial idle character that a single non-idle bit interrupts just before it would complete. From outside, this looks the same as a normal countdown unless the tick that completes the character is counted exactly. The stimulus places one low-line tick after seven idle ticks of a ten-bit frame. It then checks that the counter still holds its value nine idle ticks later and expires only on the tenth. A timeout that coincides with a software clear is also built deliberately, by asserting both on the same cycle.

// File: rtl/uit_pkg.sv
package uit_pkg;
    localparam int unsigned CNT_W     = 16;
    localparam int unsigned DLEN_W    = 4;
    localparam int unsigned MIN_DATA  = 5;
    localparam int unsigned MAX_DATA  = 9;
    localparam int unsigned MAX_CHAR  = 1 + MAX_DATA + 1 + 2;
    localparam int unsigned BIT_W     = $clog2(MAX_CHAR + 1);

    typedef enum logic [0:0] {
        ST_DISARMED = 1'b0,
        ST_COUNTING = 1'b1
    } uit_state_e;
endpackage

// File: rtl/uit_char_len.sv
module uit_char_len
    import uit_pkg::*;
(
    input  logic [DLEN_W-1:0] data_bits,
    input  logic              parity_en,
    input  logic              two_stop,
    output logic [BIT_W-1:0]  char_bits
);
    logic [DLEN_W-1:0] data_clamped;

    always_comb begin
        if (data_bits < DLEN_W'(MIN_DATA))
            data_clamped = DLEN_W'(MIN_DATA);
        else if (data_bits > DLEN_W'(MAX_DATA))
            data_clamped = DLEN_W'(MAX_DATA);
        else
            data_clamped = data_bits;
        char_bits = BIT_W'(1) + BIT_W'(data_clamped) + BIT_W'(parity_en)
                  + (two_stop ? BIT_W'(2) : BIT_W'(1));
    end
endmodule

// File: rtl/uit_bit_timer.sv
module uit_bit_timer
    import uit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             bit_tick,
    input  logic             line_idle,
    input  logic [BIT_W-1:0] char_bits,
    output logic             char_done
);
    logic [BIT_W-1:0] bit_cnt;

    assign char_done = bit_tick && line_idle && !restart
                    && (bit_cnt == char_bits - BIT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bit_cnt <= '0;
        else if (restart)
            bit_cnt <= '0;
        else if (bit_tick) begin
            if (!line_idle || char_done)
                bit_cnt <= '0;
            else
                bit_cnt <= bit_cnt + BIT_W'(1);
        end
    end
endmodule

// File: rtl/uit_ctrl_fsm.sv
module uit_ctrl_fsm
    import uit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_char_strobe,
    input  logic             char_done,
    input  logic [CNT_W-1:0] max_idle,
    input  logic             irq_clear,
    output logic             buf_close,
    output logic             irq,
    output logic [CNT_W-1:0] idle_count
);
    uit_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_d;
    logic             fire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_DISARMED;
            idle_count <= '0;
            buf_close  <= 1'b0;
            irq        <= 1'b0;
        end else begin
            state_q    <= state_d;
            idle_count <= cnt_d;
            buf_close  <= fire;
            if (fire)
                irq <= 1'b1;
            else if (irq_clear)
                irq <= 1'b0;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = idle_count;
        fire    = 1'b0;
        if (rx_char_strobe) begin
            if (max_idle != '0) begin
                state_d = ST_COUNTING;
                cnt_d   = max_idle;
            end else begin
                state_d = ST_DISARMED;
                cnt_d   = '0;
            end
        end else begin
            unique case (state_q)
                ST_DISARMED: begin
                    cnt_d = '0;
                end
                ST_COUNTING: begin
                    if (max_idle == '0) begin
                        state_d = ST_DISARMED;
                        cnt_d   = '0;
                    end else if (char_done) begin
                        if (idle_count <= CNT_W'(1)) begin
                            fire    = 1'b1;
                            state_d = ST_DISARMED;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = idle_count - CNT_W'(1);
                        end
                    end
                end
                default: begin
                    state_d = ST_DISARMED;
                    cnt_d   = '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/uart_idle_timeout.sv
module uart_idle_timeout
    import uit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              line_idle,
    input  logic              rx_char_strobe,
    input  logic [DLEN_W-1:0] data_bits,
    input  logic              parity_en,
    input  logic              two_stop,
    input  logic [CNT_W-1:0]  max_idle,
    input  logic              irq_clear,
    output logic              buf_close,
    output logic              irq,
    output logic [CNT_W-1:0]  idle_count
);
    logic [BIT_W-1:0] char_bits;
    logic             char_done;

    uit_char_len u_len (
        .data_bits (data_bits),
        .parity_en (parity_en),
        .two_stop  (two_stop),
        .char_bits (char_bits)
    );

    uit_bit_timer u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (rx_char_strobe),
        .bit_tick  (bit_tick),
        .line_idle (line_idle),
        .char_bits (char_bits),
        .char_done (char_done)
    );

    uit_ctrl_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .rx_char_strobe (rx_char_strobe),
        .char_done      (char_done),
        .max_idle       (max_idle),
        .irq_clear      (irq_clear),
        .buf_close      (buf_close),
        .irq            (irq),
        .idle_count     (idle_count)
    );
endmodule

// File: rtl/uit_chk.sv
module uit_chk
    import uit_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             rx_char_strobe,
    input logic [CNT_W-1:0] max_idle,
    input logic             irq_clear,
    input logic             buf_close,
    input logic             irq,
    input logic [CNT_W-1:0] idle_count
);
    // R2
    close_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_close |=> !buf_close);

    // R2
    close_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_close |-> idle_count == '0);

    // R8
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_close |-> irq);

    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clear) |=> irq);

    // R6
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_char_strobe && max_idle != '0) |=> idle_count == $past(max_idle));

    // R6
    no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_char_strobe |=> idle_count <= $past(idle_count));

    // R3
    disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (max_idle == '0) |=> !buf_close);
endmodule

bind uart_idle_timeout uit_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_char_strobe (rx_char_strobe),
    .max_idle       (max_idle),
    .irq_clear      (irq_clear),
    .buf_close      (buf_close),
    .irq            (irq),
    .idle_count     (idle_count)
);

// File: tb/tb_uart_idle_timeout.sv
module tb_uart_idle_timeout;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0;
    logic        line_idle = 1'b1;
    logic        rx_char_strobe = 1'b0;
    logic [3:0]  data_bits = 4'd8;
    logic        parity_en = 1'b0;
    logic        two_stop = 1'b0;
    logic [15:0] max_idle = 16'd2;
    logic        irq_clear = 1'b0;
    logic        buf_close;
    logic        irq;
    logic [15:0] idle_count;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int exp_q[$];
    bit done = 1'b0;

    uart_idle_timeout dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .bit_tick       (bit_tick),
        .line_idle      (line_idle),
        .rx_char_strobe (rx_char_strobe),
        .data_bits      (data_bits),
        .parity_en      (parity_en),
        .two_stop       (two_stop),
        .max_idle       (max_idle),
        .irq_clear      (irq_clear),
        .buf_close      (buf_close),
        .irq            (irq),
        .idle_count     (idle_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: every close pulse must match the next expected cycle.
    always @(negedge clk) begin
        if (rst_n && buf_close) begin
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R7 actual=unexpected close at %0d expected=none", cyc);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (e != cyc) begin
                    fails++;
                    $display("FAIL R2 actual=close at %0d expected=%0d", cyc, e);
                end
            end
        end
    end

    // Driver: n ticks, pushing the expected close cycle on the last one.
    task automatic tick_run(int n, bit idle, bit expect_close);
        for (int i = 0; i < n; i++) begin
            if (expect_close && i == n - 1) exp_q.push_back(cyc + 1);
            bit_tick  = 1'b1;
            line_idle = idle;
            @(negedge clk);
        end
        bit_tick  = 1'b0;
        line_idle = 1'b1;
    endtask

    task automatic strobe();
        rx_char_strobe = 1'b1;
        @(negedge clk);
        rx_char_strobe = 1'b0;
    endtask

    task automatic clear_irq();
        irq_clear = 1'b1;
        @(negedge clk);
        irq_clear = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=expired expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 buf_close", buf_close, 0);
        chk("R9 irq", irq, 0);
        chk("R9 idle_count", idle_count, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 no counting before a character
        tick_run(25, 1'b1, 1'b0);
        chk("R1 idle_count", idle_count, 0);
        chk("R1 irq", irq, 0);

        // R6 reload, R4 8N1 = 10 ticks, R2 expire
        max_idle = 16'd2;
        strobe();
        chk("R6 load", idle_count, 2);
        tick_run(9, 1'b1, 1'b0);
        chk("R4 8N1 not yet", idle_count, 2);
        tick_run(1, 1'b1, 1'b0);
        chk("R4 8N1 one char", idle_count, 1);
        tick_run(10, 1'b1, 1'b1);
        chk("R2 count zero", idle_count, 0);
        chk("R8 irq set", irq, 1);
        // R7 no retrigger
        tick_run(30, 1'b1, 1'b0);
        chk("R7 count stays", idle_count, 0);
        chk("R8 irq held", irq, 1);
        clear_irq();
        chk("R8 irq cleared", irq, 0);

        // R4 5 data, parity, 2 stop = 9 ticks
        data_bits = 4'd5; parity_en = 1'b1; two_stop = 1'b1; max_idle = 16'd1;
        strobe();
        tick_run(8, 1'b1, 1'b0);
        chk("R4 5E2 not yet", idle_count, 1);
        tick_run(1, 1'b1, 1'b1);
        clear_irq();

        // R4 clamp: 2 -> 5 data, no parity, 1 stop = 7 ticks
        data_bits = 4'd2; parity_en = 1'b0; two_stop = 1'b0;
        strobe();
        tick_run(6, 1'b1, 1'b0);
        chk("R4 clamp not yet", idle_count, 1);
        tick_run(1, 1'b1, 1'b1);
        clear_irq();

        // R4 9 data, parity, 2 stop = 13 ticks
        data_bits = 4'd9; parity_en = 1'b1; two_stop = 1'b1;
        strobe();
        tick_run(12, 1'b1, 1'b0);
        chk("R4 9E2 not yet", idle_count, 1);
        tick_run(1, 1'b1, 1'b1);
        clear_irq();

        // R5 activity restarts the character
        data_bits = 4'd8; parity_en = 1'b0; two_stop = 1'b0;
        strobe();
        tick_run(7, 1'b1, 1'b0);
        tick_run(1, 1'b0, 1'b0);
        tick_run(9, 1'b1, 1'b0);
        chk("R5 restarted", idle_count, 1);
        tick_run(1, 1'b1, 1'b1);
        clear_irq();

        // R6 reload mid-count
        max_idle = 16'd2;
        strobe();
        tick_run(15, 1'b1, 1'b0);
        chk("R6 partway", idle_count, 1);
        max_idle = 16'd3;
        strobe();
        chk("R6 reloaded", idle_count, 3);
        tick_run(30, 1'b1, 1'b1);
        clear_irq();

        // R3 disabled
        max_idle = 16'd0;
        strobe();
        tick_run(50, 1'b1, 1'b0);
        chk("R3 count", idle_count, 0);
        chk("R3 irq", irq, 0);

        // R8 timeout wins over simultaneous clear
        max_idle = 16'd1;
        strobe();
        tick_run(9, 1'b1, 1'b0);
        exp_q.push_back(cyc + 1);
        bit_tick = 1'b1; irq_clear = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0; irq_clear = 1'b0;
        chk("R8 set wins", irq, 1);

        repeat (5) @(negedge clk);
        chk("R2 all expected closes seen", exp_q.size(), 0);
        finish_run();
    end
endmodule